// File: doc/BRIEF.md
# Low-Voltage Detect Status Register

This block is the 8-bit status and control register of a low-voltage detection unit, reached over a simple single-cycle peripheral bus. Three comparator outputs enter it asynchronously: the supply is under the drop threshold, the supply is over the rise threshold, and the supply is under the reset threshold. Each one passes through a two-flop synchronizer. A one-cycle overflow pulse from the stabilization counter and a rise-detect enable from the companion control register arrive already synchronous.

The register holds three sticky flags: drop, rise and stabilized. Software clears a flag only by reading it as 1 and then writing 0 to it. The rise flag needs an ordered sequence. First the supply falls under the drop threshold while the enable is 1. Then it climbs over the rise threshold before it ever crosses the reset threshold. A small armed state holds the pending drop between those two events. The register also holds one control bit that selects an external reference instead of the on-chip one, and four spare bits that are plain storage.

There are three reset inputs. Power-on clears everything. The detector's own reset clears only the flags and the sequence state. The general system reset clears only the control and spare bits.

Top module: `lvd_status_reg`

## Requirements
- R1: The register answers only at byte address 0x87, with bus_sel=1 and bus_rd=1 for a read. At any other address, or when no read is active, bus_rdata is 0x00. Writes to other addresses change nothing.
- R2: Bit layout: bit 7 is the stabilized flag, bit 3 selects the external reference, bit 1 is the drop flag and bit 0 is the rise flag. After power-on reset the register reads 0x00.
- R3: A 0-to-1 change on cmp_below_drop sets the drop flag at the third rising clock edge after the change. At the second edge the flag is still 0.
- R4: The rise flag sets when a 0-to-1 change on cmp_above_rise follows a drop edge that was taken while rise_det_en=1, with no reset-threshold crossing in between. Like the drop flag, it becomes visible three edges after the comparator change.
- R5: A synchronized cmp_below_reset=1 cancels a pending drop. A drop edge taken while rise_det_en=0 arms nothing. In both cases a later rise sets no rise flag.
- R6: A one-cycle stab_cnt_ovf pulse sets the stabilized flag at the next clock edge.
- R7: A flag clears when a write to the register carries 0 in that flag's bit, and only if the flag was read as 1 since the last write. A write of 0 without such a read leaves the flag set.
- R8: Writing 1 to a flag bit never changes the flag. Any write to the register uses up the "read as 1" state.
- R9: A set event in the same cycle as a valid clear wins, and the flag stays 1.
- R10: Bit 3 and the spare bits 6, 5, 4 and 2 store what is written and read it back. Bit 3 also drives ref_ext_sel.
- R11: lvd_rst_n clears the three flags and leaves bit 3 and the spare bits alone. sys_rst_n clears bit 3 and the spare bits and leaves the flags alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| lvd_rst_n | input | 1 | Reset from the voltage detector, active low, clears flags and sequence state |
| sys_rst_n | input | 1 | General system reset, active low, clears control and spare bits |
| bus_sel | input | 1 | Peripheral select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| cmp_below_drop | input | 1 | Asynchronous comparator: supply under the drop threshold |
| cmp_above_rise | input | 1 | Asynchronous comparator: supply over the rise threshold |
| cmp_below_reset | input | 1 | Asynchronous comparator: supply under the reset threshold |
| rise_det_en | input | 1 | Rise-detect enable from the control register |
| stab_cnt_ovf | input | 1 | Overflow pulse from the stabilization counter |
| ref_ext_sel | output | 1 | 1 selects the external reference, 0 the on-chip one |

## Verification
Read data is combinational, so a read reflects the state after the previous edge. A write or an overflow pulse shows up one edge later. A comparator change has two synchronizer edges in front of it, so it shows up on the third edge. Inputs are driven at the falling edge and bus_rdata is sampled 1 ns later. The directed cases read once after the second edge and expect the old value, then read after the third edge and expect the new one. In the random phase, a bench model keeps its own three-deep copy of each comparator's history and advances on the same rising edges, and every read is compared against it.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_RISE  = 0;
  localparam int FLG_DROP  = 1;
  localparam int FLG_OVF   = 2;

  localparam int BIT_RISE  = 0;
  localparam int BIT_DROP  = 1;
  localparam int BIT_REF   = 3;
  localparam int BIT_OVF   = 7;
  localparam logic [7:0] SPARE_MASK = 8'h74;

  // comparator vector index
  localparam int CMP_DROP  = 0;
  localparam int CMP_RISE  = 1;
  localparam int CMP_RST   = 2;
  localparam int NUM_CMP   = 3;

  function automatic int flag_pos(input int idx);
    case (idx)
      FLG_RISE: return BIT_RISE;
      FLG_DROP: return BIT_DROP;
      default:  return BIT_OVF;
    endcase
  endfunction

  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [7:0] pack_reg(input logic [NUM_FLAGS-1:0] flg,
                                          input logic refsel,
                                          input logic [7:0] spare);
    logic [7:0] v;
    v = spare & SPARE_MASK;
    v[BIT_REF]  = refsel;
    v[BIT_RISE] = flg[FLG_RISE];
    v[BIT_DROP] = flg[FLG_DROP];
    v[BIT_OVF]  = flg[FLG_OVF];
    return v;
  endfunction
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] chain [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q   = chain[STAGES-1];
  assign q_d = chain[STAGES];
endmodule

// File: rtl/lvd_seq.sv
module lvd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic below_drop_s,
  input  logic below_drop_d,
  input  logic above_rise_s,
  input  logic above_rise_d,
  input  logic below_reset_s,
  input  logic rise_en,
  output logic drop_evt,
  output logic rise_evt,
  output logic armed
);
  logic rise_edge;

  assign drop_evt  = below_drop_s & ~below_drop_d;
  assign rise_edge = above_rise_s & ~above_rise_d;
  assign rise_evt  = armed & rise_edge & ~below_reset_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed <= 1'b0;
    else if (below_reset_s) armed <= 1'b0;
    else if (drop_evt)      armed <= rise_en;
    else if (rise_evt)      armed <= 1'b0;
  end
endmodule

// File: rtl/lvd_flag_bit.sv
module lvd_flag_bit import lvd_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wbit,
  output logic flag,
  output logic seen,
  output logic clr
);
  assign clr = wr_hit & ~wbit & seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      seen <= 1'b0;
    end else begin
      flag <= flag_next(flag, set_i, clr);
      if (wr_hit)               seen <= 1'b0;
      else if (rd_hit && flag)  seen <= 1'b1;
    end
  end
endmodule

// File: rtl/lvd_status_reg.sv
module lvd_status_reg import lvd_pkg::*; #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h87,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              lvd_rst_n,
  input  logic              sys_rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp_below_drop,
  input  logic              cmp_above_rise,
  input  logic              cmp_below_reset,
  input  logic              rise_det_en,
  input  logic              stab_cnt_ovf,
  output logic              ref_ext_sel
);
  logic flag_rst_n, ctl_rst_n;
  assign flag_rst_n = por_n & lvd_rst_n;
  assign ctl_rst_n  = por_n & sys_rst_n;

  logic hit, rd_hit, wr_hit;
  assign hit    = bus_sel && (bus_addr == REG_ADDR);
  assign rd_hit = hit && bus_rd;
  assign wr_hit = hit && bus_wr;

  // comparator synchronizers
  logic [NUM_CMP-1:0] cmp_raw, cmp_s, cmp_d;
  assign cmp_raw[CMP_DROP] = cmp_below_drop;
  assign cmp_raw[CMP_RISE] = cmp_above_rise;
  assign cmp_raw[CMP_RST]  = cmp_below_reset;

  lvd_sync #(.W(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .d(cmp_raw), .q(cmp_s), .q_d(cmp_d)
  );

  // event sequencing
  logic drop_evt, rise_evt, armed;
  logic below_reset_s;
  assign below_reset_s = cmp_s[CMP_RST];

  lvd_seq u_seq (
    .clk(clk), .rst_n(flag_rst_n),
    .below_drop_s(cmp_s[CMP_DROP]), .below_drop_d(cmp_d[CMP_DROP]),
    .above_rise_s(cmp_s[CMP_RISE]), .above_rise_d(cmp_d[CMP_RISE]),
    .below_reset_s(below_reset_s), .rise_en(rise_det_en),
    .drop_evt(drop_evt), .rise_evt(rise_evt), .armed(armed)
  );

  // sticky flags
  logic [NUM_FLAGS-1:0] set_vec, flags, seen, clr_vec;
  assign set_vec[FLG_RISE] = rise_evt;
  assign set_vec[FLG_DROP] = drop_evt;
  assign set_vec[FLG_OVF]  = stab_cnt_ovf;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    lvd_flag_bit u_flag (
      .clk(clk), .rst_n(flag_rst_n), .set_i(set_vec[g]),
      .rd_hit(rd_hit), .wr_hit(wr_hit), .wbit(bus_wdata[flag_pos(g)]),
      .flag(flags[g]), .seen(seen[g]), .clr(clr_vec[g])
    );
  end

  // control and spare storage
  logic [DATA_W-1:0] spare_q;
  logic              refsel_q;

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      spare_q  <= '0;
      refsel_q <= 1'b0;
    end else if (wr_hit) begin
      spare_q  <= bus_wdata & SPARE_MASK;
      refsel_q <= bus_wdata[BIT_REF];
    end
  end

  assign ref_ext_sel = refsel_q;
  assign bus_rdata   = rd_hit ? pack_reg(flags, refsel_q, spare_q) : '0;
endmodule

// File: rtl/lvd_status_chk.sv
module lvd_status_chk import lvd_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic                 clk,
  input logic                 por_n,
  input logic                 lvd_rst_n,
  input logic                 sys_rst_n,
  input logic                 wr_hit,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 stab_cnt_ovf,
  input logic                 drop_evt,
  input logic                 armed,
  input logic                 below_reset_s,
  input logic                 ref_ext_sel,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] seen,
  input logic [NUM_FLAGS-1:0] set_vec
);
  assert_drop_cause_R3: assert property (@(posedge clk) disable iff (!por_n || !lvd_rst_n)
    $rose(flags[FLG_DROP]) |-> $past(drop_evt));

  assert_rise_armed_R4: assert property (@(posedge clk) disable iff (!por_n || !lvd_rst_n)
    $rose(flags[FLG_RISE]) |-> $past(armed));

  assert_cancel_R5: assert property (@(posedge clk) disable iff (!por_n || !lvd_rst_n)
    below_reset_s |=> !armed);

  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!por_n || !lvd_rst_n)
    $rose(flags[FLG_OVF]) |-> $past(stab_cnt_ovf));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_chk
    assert_noread_keeps_R7: assert property (@(posedge clk) disable iff (!por_n || !lvd_rst_n)
      (wr_hit && flags[g] && !seen[g]) |=> flags[g]);
    assert_wr1_keeps_R8: assert property (@(posedge clk) disable iff (!por_n || !lvd_rst_n)
      (wr_hit && flags[g] && bus_wdata[flag_pos(g)]) |=> flags[g]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!por_n || !lvd_rst_n)
      set_vec[g] |=> flags[g]);
  end

  assert_refsel_R10: assert property (@(posedge clk) disable iff (!por_n)
    (wr_hit && sys_rst_n) |=> (!sys_rst_n || ref_ext_sel == $past(bus_wdata[BIT_REF])));

  assert_lvdrst_R11: assert property (@(posedge clk) disable iff (!por_n)
    !lvd_rst_n |-> (flags == '0));
endmodule

bind lvd_status_reg lvd_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .por_n(por_n), .lvd_rst_n(lvd_rst_n), .sys_rst_n(sys_rst_n),
  .wr_hit(wr_hit), .bus_wdata(bus_wdata), .stab_cnt_ovf(stab_cnt_ovf),
  .drop_evt(drop_evt), .armed(armed), .below_reset_s(below_reset_s),
  .ref_ext_sel(ref_ext_sel), .flags(flags), .seen(seen), .set_vec(set_vec)
);

// File: tb/sim_lvd_status_reg.sv
module sim_lvd_status_reg;
  localparam logic [7:0] A = 8'h87;

  logic clk = 0;
  logic por_n = 0, lvd_rst_n = 1, sys_rst_n = 1;
  logic sel = 0, rd = 0, wr = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic c_drop = 0, c_rise = 0, c_rst = 0, en = 0, ovf = 0;
  logic refsel;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lvd_status_reg u0 (
    .clk(clk), .por_n(por_n), .lvd_rst_n(lvd_rst_n), .sys_rst_n(sys_rst_n),
    .bus_sel(sel), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .cmp_below_drop(c_drop), .cmp_above_rise(c_rise), .cmp_below_reset(c_rst),
    .rise_det_en(en), .stab_cnt_ovf(ovf), .ref_ext_sel(refsel)
  );

  // bench model: flags {ovf,drop,rise}, seen, arm, control, history
  logic [2:0] mf = 0, ms = 0;
  logic marm = 0, mref = 0;
  logic [7:0] mspare = 0;
  logic [2:0] h1 = 0, h2 = 0, h3 = 0;

  function automatic logic [7:0] model_byte(input logic [2:0] f, input logic r, input logic [7:0] sp);
    return {f[2], sp[6:4], r, sp[2], f[1], f[0]};
  endfunction

  always @(posedge clk) begin
    logic hitw, hitr, de, ae, br;
    logic [2:0] st, cl, nf;
    logic [2:0] wb;
    hitr = sel && rd && addr == A;
    hitw = sel && wr && addr == A;
    de = h2[0] & ~h3[0];
    ae = h2[1] & ~h3[1];
    br = h2[2];
    wb = {wdata[7], wdata[1], wdata[0]};
    st = {ovf, de, marm & ae & ~br};
    cl = {3{hitw}} & ~wb & ms;
    nf = st | (mf & ~cl);
    if (!por_n || !lvd_rst_n) begin
      mf = 0; ms = 0; marm = 0;
    end else begin
      ms = hitw ? 3'b000 : (ms | ({3{hitr}} & mf));
      mf = nf;
      if (br) marm = 0;
      else if (de) marm = en;
      else if (st[0]) marm = 0;
    end
    if (!por_n || !sys_rst_n) begin
      mref = 0; mspare = 0;
    end else if (hitw) begin
      mref = wdata[3]; mspare = wdata & 8'h74;
    end
    if (!por_n) begin h1 = 0; h2 = 0; h3 = 0; end
    else begin h3 = h2; h2 = h1; h1 = {c_rst, c_rise, c_drop}; end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    sel = 1; rd = 1; addr = a;
    #1 check(rdata, exp, req);
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ovf();
    ovf = 1; @(negedge clk); ovf = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2); por_n = 1; idle(2);
    rd_chk(A, 8'h00, "R2 reset value");
    sel = 1; rd = 1; addr = 8'h86; #1 check(rdata, 8'h00, "R1 wrong address"); @(negedge clk); sel = 0; rd = 0;
    wr_reg(8'h86, 8'hFF);
    rd_chk(A, 8'h00, "R1 write elsewhere ignored");
    pulse_ovf();
    rd_chk(A, 8'h80, "R6 overflow sets flag");
    // read done above -> seen; now write 0 with seen clears; first test unread write
    wr_reg(A, 8'hFF);               // consumes seen, writes 1 to flag bits
    rd_chk(A, 8'hFC, "R8 write 1 no effect, R10 control bits stored");
    wr_reg(A, 8'hFC);               // consumes seen again
    wr_reg(A, 8'h7C);               // no read since last write
    rd_chk(A, 8'hFC, "R7 clear without read ignored");
    wr_reg(A, 8'h7C);               // after read as 1
    rd_chk(A, 8'h7C, "R7 read-then-write-0 clears");
    pulse_ovf();
    rd_chk(A, 8'hFC, "R6 flag set again");
    ovf = 1; wr_reg(A, 8'h7C); ovf = 0;
    rd_chk(A, 8'hFC, "R9 set wins over clear");
    check({7'b0, refsel}, 8'h01, "R10 ref_ext_sel pin");
    sys_rst_n = 0; idle(2); sys_rst_n = 1; idle(1);
    rd_chk(A, 8'h80, "R11 system reset keeps flags");
    wr_reg(A, 8'h08);
    lvd_rst_n = 0; idle(2); lvd_rst_n = 1; idle(1);
    rd_chk(A, 8'h08, "R11 detector reset clears flags only");
    wr_reg(A, 8'h00);
    // drop then rise, enable on
    en = 1;
    c_drop = 1; idle(2);
    rd_chk(A, 8'h00, "R3 drop flag not yet after two edges");
    rd_chk(A, 8'h02, "R3 drop flag after three edges");
    c_drop = 0; c_rise = 1; idle(2);
    rd_chk(A, 8'h02, "R4 rise flag not yet");
    rd_chk(A, 8'h03, "R4 rise flag after sequence");
    wr_reg(A, 8'h00);
    rd_chk(A, 8'h00, "R7 both flags cleared");
    c_rise = 0; idle(4);
    // cancel by reset-threshold crossing
    c_drop = 1; idle(4); c_rst = 1; idle(4); c_rst = 0; c_drop = 0; idle(4);
    c_rise = 1; idle(4);
    rd_chk(A, 8'h02, "R5 reset crossing cancels rise");
    wr_reg(A, 8'h00); c_rise = 0; idle(4);
    // enable off at drop time
    en = 0; c_drop = 1; idle(4); en = 1; c_drop = 0; idle(2); c_rise = 1; idle(4);
    rd_chk(A, 8'h02, "R5 disabled drop arms nothing");
    wr_reg(A, 8'h00); c_rise = 0; idle(4);

    // constrained random phase against the bench model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      en     = ($urandom_range(0, 3) != 0);
      ovf    = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 15) == 0) c_drop = ~c_drop;
      if ($urandom_range(0, 15) == 0) c_rise = ~c_rise;
      if ($urandom_range(0, 40) == 0) c_rst  = ~c_rst;
      if (r < 45) begin
        sel = 1; rd = 1; addr = ($urandom_range(0, 7) == 0) ? 8'h86 : A;
        #1 check(rdata, (addr == A) ? model_byte(mf, mref, mspare) : 8'h00, "R1-model random read");
      end else if (r < 70) begin
        sel = 1; wr = 1; addr = A;
        wdata = ($urandom_range(0, 1) != 0) ? 8'h00 : 8'($urandom);
      end
      @(negedge clk);
      sel = 0; rd = 0; wr = 0; ovf = 0;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule